// File: doc/BRIEF.md
# Indirect Parameter Window Bridge

This block sits between a byte-wide control bus and the parameter store of a two-channel waveform player. The control bus reaches only 64 byte locations. Most of them are fixed identity bytes or unused. Four of them form a 32-bit data pointer, and one is a window byte. A read or write of the window reaches the data-space location that the pointer names. Through the window, software can fill the two sample memories and set each channel's filter-switch byte, its 32-bit clock divisor and its 16-bit waveform length.

The sample memories themselves are outside the block. It drives one shared write port for them: a per-channel strobe, an index and a byte. When reset ends, the block uses that port to fill every entry of both memories with mid-scale (128). It refuses control requests until the fill is complete. Divisor and length values reach the players through a shadow stage. That stage is reloaded only when the channel's player signals a waveform wrap, so a value that is half written never reaches a running channel. Filter-switch bytes take effect at once.

Control requests use a valid/ready handshake. `cs_ready` is low from reset until the fill has finished, then stays high, and a request counts only in a cycle where both `cs_valid` and `cs_ready` are high. The requester must hold its request stable while `cs_ready` is low. Each accepted read returns exactly one response, with `rsp_valid` high for one cycle in the cycle after acceptance. The response path has no back-pressure. The sample write port has no back-pressure either: the memories take one byte per cycle.

Top module: `fgb_portal_bridge`

## Requirements
- R1: After reset, the exported filter-switch byte of each channel is 1, and every exported divisor and length bit is 0.
- R2: After reset, `cs_ready` stays low while the block writes 128 to both memories at once, at indices 0 up to 2^SAMPLE_AW-1, rising by one each cycle. `cs_ready` then goes high.
- R3: Reads of control address 0x00, 0x12 and 0x13 return the HW_ID, HW_VER and SW_VER parameters. Reads of other unassigned control addresses return 0x00. Writes to any of these addresses change nothing.
- R4: Control addresses 0x18, 0x19, 0x1A and 0x1B hold the data pointer from its most significant byte to its least significant byte, and each one reads back what was last written to it.
- R5: A window write (control address 0x3F) to data address 0x0000 to 0x1FFF pulses `smp_we[0]` for one cycle, and one to 0x4000 to 0x5FFF pulses `smp_we[1]`. The index is the low 13 bits of the pointer, and the write data appears on `smp_data`. All three outputs are valid in the cycle after acceptance, and only one strobe is high.
- R6: Data address 0x8000 holds the filter-switch byte of channel 0 and 0x8001 that of channel 1. A window write appears on `ch_rc` in the next cycle and can be read back through the window.
- R7: The divisor of channel 0 sits at 0x8002 to 0x8005 and that of channel 1 at 0x8006 to 0x8009. The length of channel 0 sits at 0x800A to 0x800B and that of channel 1 at 0x800C to 0x800D. In each register the most significant byte is at the lowest address, and every byte reads back through the window.
- R8: The exported divisor and length of a channel change only in the cycle after that channel's `wrap` bit is high. They then take the values last written to the channel's divisor and length bytes.
- R9: Only the low 16 bits of the data pointer are decoded. Window writes to undecoded data addresses change nothing. Window reads of undecoded addresses and of the sample ranges return 0x00.
- R10: `rsp_valid` is high for exactly the cycle after each accepted read, and never at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_valid | input | 1 | Control request valid |
| cs_ready | output | 1 | Control request accepted when high with cs_valid |
| cs_write | input | 1 | 1 = write, 0 = read |
| cs_addr | input | 6 | Control-space byte address |
| cs_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid (one cycle) |
| rsp_data | output | 8 | Read response byte |
| smp_we | output | 2 | Sample memory write strobe, bit per channel |
| smp_addr | output | SAMPLE_AW | Sample memory index |
| smp_data | output | 8 | Sample memory write byte |
| wrap | input | 2 | Waveform wrap pulse from each channel player |
| ch_rc | output | 16 | Filter-switch bytes, channel 0 in bits 7:0 |
| ch_div | output | 64 | Active divisors, channel 0 in bits 31:0 |
| ch_len | output | 32 | Active lengths, channel 0 in bits 15:0 |

## Verification
The assertions assume a requester that follows the handshake: it holds its request stable while `cs_ready` is low, and it never writes both sample channels in the same cycle. The block cannot do the latter, because the pointer selects a single region. They also assume that reset is applied before the first clock edge. The bench starts in reset and changes inputs only on falling edges. It issues single-cycle requests only after `cs_ready` has risen, and it pulses `wrap` only between requests, so every shadow reload and every readback falls in a cycle the bench can name. The random traffic covers decoded bytes, undecoded words, sample writes and random upper pointer bits.

// File: rtl/fgb_pkg.sv
package fgb_pkg;
  localparam logic [5:0] CA_ID     = 6'h00;
  localparam logic [5:0] CA_HWVER  = 6'h12;
  localparam logic [5:0] CA_SWVER  = 6'h13;
  localparam logic [5:0] CA_PTR3   = 6'h18;
  localparam logic [5:0] CA_PTR2   = 6'h19;
  localparam logic [5:0] CA_PTR1   = 6'h1A;
  localparam logic [5:0] CA_PTR0   = 6'h1B;
  localparam logic [5:0] CA_WINDOW = 6'h3F;

  localparam int unsigned SMP0_BASE = 32'h0000;
  localparam int unsigned SMP1_BASE = 32'h4000;
  localparam int unsigned REG_BASE  = 32'h8000;
  localparam logic [7:0]  MID_SCALE = 8'd128;
endpackage

// File: rtl/fgb_init_sweep.sv
module fgb_init_sweep #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          busy,
  output logic [AW-1:0] idx
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      if (idx == {AW{1'b1}}) busy <= 1'b0;
      else idx <= idx + 1'b1;
    end
  end

  assert_sweep_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx != {AW{1'b1}}) |=> (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/fgb_reg_file.sv
module fgb_reg_file #(
  parameter int NCH   = 2,
  parameter int DIV_W = 32,
  parameter int LEN_W = 16,
  localparam int DB   = DIV_W / 8,
  localparam int LB   = LEN_W / 8,
  localparam int NREG = NCH * (1 + DB + LB),
  localparam int IW   = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IW-1:0]      widx,
  input  logic [7:0]         wdata,
  input  logic [IW-1:0]      ridx,
  output logic [7:0]         rdata,
  output logic [NCH*8-1:0]   rc,
  output logic [NCH*DIV_W-1:0] div,
  output logic [NCH*LEN_W-1:0] len
);
  logic [7:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= (i < NCH) ? 8'd1 : 8'd0;
    end else if (we && (widx < IW'(NREG))) begin
      regs[widx] <= wdata;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (ridx < IW'(NREG)) rdata = regs[ridx];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign rc[c*8 +: 8] = regs[c];
    for (genvar b = 0; b < DB; b++) begin : g_div
      assign div[c*DIV_W + (DB-1-b)*8 +: 8] = regs[NCH + c*DB + b];
    end
    for (genvar b = 0; b < LB; b++) begin : g_len
      assign len[c*LEN_W + (LB-1-b)*8 +: 8] = regs[NCH + NCH*DB + c*LB + b];
    end
  end
endmodule

// File: rtl/fgb_shadow.sv
module fgb_shadow #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] staged,
  output logic [W-1:0] active
);
  always_ff @(posedge clk) begin
    if (!rst_n)    active <= '0;
    else if (load) active <= staged;
  end

  assert_hold_between_wraps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(active));
endmodule

// File: rtl/fgb_portal_bridge.sv
module fgb_portal_bridge #(
  parameter int         SAMPLE_AW = 13,
  parameter int         DIV_W     = 32,
  parameter int         LEN_W     = 16,
  parameter logic [7:0] HW_ID     = 8'h5A,
  parameter logic [7:0] HW_VER    = 8'h03,
  parameter logic [7:0] SW_VER    = 8'h07
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_valid,
  output logic                   cs_ready,
  input  logic                   cs_write,
  input  logic [5:0]             cs_addr,
  input  logic [7:0]             cs_wdata,
  output logic                   rsp_valid,
  output logic [7:0]             rsp_data,
  output logic [1:0]             smp_we,
  output logic [SAMPLE_AW-1:0]   smp_addr,
  output logic [7:0]             smp_data,
  input  logic [1:0]             wrap,
  output logic [15:0]            ch_rc,
  output logic [2*DIV_W-1:0]     ch_div,
  output logic [2*LEN_W-1:0]     ch_len
);
  import fgb_pkg::*;

  localparam int NCH  = 2;
  localparam int NREG = NCH * (1 + DIV_W/8 + LEN_W/8);
  localparam int IW   = $clog2(NREG);
  localparam int SPAN = 1 << SAMPLE_AW;

  logic                 busy;
  logic [SAMPLE_AW-1:0] fill_idx;
  logic [31:0]          dptr;
  logic [15:0]          lo;
  logic                 wr_acc, rd_acc, win_wr;
  logic                 in_smp0, in_smp1, in_reg;
  logic [7:0]           reg_rdata, rd_mux;
  logic [NCH*DIV_W-1:0] st_div;
  logic [NCH*LEN_W-1:0] st_len;

  fgb_init_sweep #(.AW(SAMPLE_AW)) u_sweep (
    .clk(clk), .rst_n(rst_n), .busy(busy), .idx(fill_idx)
  );

  assign cs_ready = !busy;
  assign wr_acc   = cs_valid && cs_ready && cs_write;
  assign rd_acc   = cs_valid && cs_ready && !cs_write;
  assign win_wr   = wr_acc && (cs_addr == CA_WINDOW);
  assign lo       = dptr[15:0];

  assign in_smp0 = (32'(lo) >= SMP0_BASE) && (32'(lo) < SMP0_BASE + 32'(SPAN));
  assign in_smp1 = (32'(lo) >= SMP1_BASE) && (32'(lo) < SMP1_BASE + 32'(SPAN));
  assign in_reg  = (32'(lo) >= REG_BASE)  && (32'(lo) < REG_BASE + 32'(NREG));

  always_ff @(posedge clk) begin
    if (!rst_n) dptr <= '0;
    else if (wr_acc) begin
      case (cs_addr)
        CA_PTR3: dptr[31:24] <= cs_wdata;
        CA_PTR2: dptr[23:16] <= cs_wdata;
        CA_PTR1: dptr[15:8]  <= cs_wdata;
        CA_PTR0: dptr[7:0]   <= cs_wdata;
        default: ;
      endcase
    end
  end

  fgb_reg_file #(.NCH(NCH), .DIV_W(DIV_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we(win_wr && in_reg), .widx(lo[IW-1:0]), .wdata(cs_wdata),
    .ridx(lo[IW-1:0]), .rdata(reg_rdata),
    .rc(ch_rc), .div(st_div), .len(st_len)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_shadow
    fgb_shadow #(.W(DIV_W + LEN_W)) u_sh (
      .clk(clk), .rst_n(rst_n), .load(wrap[c]),
      .staged({st_len[c*LEN_W +: LEN_W], st_div[c*DIV_W +: DIV_W]}),
      .active({ch_len[c*LEN_W +: LEN_W], ch_div[c*DIV_W +: DIV_W]})
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_we   <= '0;
      smp_addr <= '0;
      smp_data <= '0;
    end else if (busy) begin
      smp_we   <= 2'b11;
      smp_addr <= fill_idx;
      smp_data <= MID_SCALE;
    end else begin
      smp_we   <= {win_wr && in_smp1, win_wr && in_smp0};
      smp_addr <= lo[SAMPLE_AW-1:0];
      smp_data <= cs_wdata;
    end
  end

  always_comb begin
    case (cs_addr)
      CA_ID:     rd_mux = HW_ID;
      CA_HWVER:  rd_mux = HW_VER;
      CA_SWVER:  rd_mux = SW_VER;
      CA_PTR3:   rd_mux = dptr[31:24];
      CA_PTR2:   rd_mux = dptr[23:16];
      CA_PTR1:   rd_mux = dptr[15:8];
      CA_PTR0:   rd_mux = dptr[7:0];
      CA_WINDOW: rd_mux = in_reg ? reg_rdata : 8'h00;
      default:   rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_acc;
      if (rd_acc) rsp_data <= rd_mux;
    end
  end

  assert_fill_midscale_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(smp_we) == 2) |-> (smp_data == MID_SCALE));

  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_ready) && (smp_we != 2'b00)) |-> ($countones(smp_we) == 1));

  assert_rsp_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cs_valid && cs_ready && !cs_write));

  assert_undecoded_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && !in_reg) |=> $stable({ch_rc, st_div, st_len}));
endmodule

// File: tb/fgb_portal_bridge_tb_top.sv
module fgb_portal_bridge_tb_top;
  localparam int AW = 13;
  localparam logic [7:0] ID = 8'h5A, HV = 8'h03, SV = 8'h07;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_valid = 1'b0, cs_write = 1'b0;
  logic [5:0] cs_addr = '0;
  logic [7:0] cs_wdata = '0;
  logic [1:0] wrap = '0;
  logic cs_ready, rsp_valid;
  logic [7:0] rsp_data, smp_data;
  logic [1:0] smp_we;
  logic [AW-1:0] smp_addr;
  logic [15:0] ch_rc;
  logic [63:0] ch_div;
  logic [31:0] ch_len;

  int n_chk = 0, n_err = 0;

  logic [7:0]  m [14];
  logic [31:0] a_div [2];
  logic [15:0] a_len [2];

  always #10 clk = ~clk;

  fgb_portal_bridge #(.SAMPLE_AW(AW), .HW_ID(ID), .HW_VER(HV), .SW_VER(SV)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_valid(cs_valid), .cs_ready(cs_ready),
    .cs_write(cs_write), .cs_addr(cs_addr), .cs_wdata(cs_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .smp_we(smp_we),
    .smp_addr(smp_addr), .smp_data(smp_data), .wrap(wrap),
    .ch_rc(ch_rc), .ch_div(ch_div), .ch_len(ch_len)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_div(input int c);
    return {m[2+4*c], m[3+4*c], m[4+4*c], m[5+4*c]};
  endfunction
  function automatic logic [15:0] m_len(input int c);
    return {m[10+2*c], m[11+2*c]};
  endfunction

  task automatic cwr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_valid = 1'b1; cs_write = 1'b1; cs_addr = a; cs_wdata = d;
    @(negedge clk);
    cs_valid = 1'b0; cs_write = 1'b0;
  endtask

  task automatic crd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_valid = 1'b1; cs_write = 1'b0; cs_addr = a;
    @(negedge clk);
    cs_valid = 1'b0;
    check("R10 rsp_valid after read", rsp_valid, 1'b1);
    d = rsp_data;
  endtask

  task automatic set_ptr(input logic [31:0] p);
    cwr(6'h18, p[31:24]); cwr(6'h19, p[23:16]);
    cwr(6'h1A, p[15:8]);  cwr(6'h1B, p[7:0]);
  endtask

  task automatic pwr(input logic [31:0] p, input logic [7:0] d);
    set_ptr(p);
    cwr(6'h3F, d);
  endtask

  task automatic prd(input logic [31:0] p, output logic [7:0] d);
    set_ptr(p);
    crd(6'h3F, d);
  endtask

  task automatic pulse_wrap(input logic [1:0] w);
    @(negedge clk); wrap = w;
    @(negedge clk); wrap = 2'b00;
    for (int c = 0; c < 2; c++) if (w[c]) begin a_div[c] = m_div(c); a_len[c] = m_len(c); end
  endtask

  task automatic check_exports(input string req);
    check(req, ch_rc, {m[1], m[0]});
    check(req, ch_div, {a_div[1], a_div[0]});
    check(req, ch_len, {a_len[1], a_len[0]});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    int fills, bad, exp_idx;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 14; i++) m[i] = (i < 2) ? 8'd1 : 8'd0;
    for (int c = 0; c < 2; c++) begin a_div[c] = '0; a_len[c] = '0; end

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_exports("R1 reset exports");

    fills = 0; bad = 0; exp_idx = 0;
    // R2: fill sweep observed at the sample port while cs_ready is low
    while (!cs_ready) begin
      if (smp_we == 2'b11) begin
        if (smp_addr != AW'(exp_idx) || smp_data != 8'd128) bad++;
        exp_idx++; fills++;
      end
      @(negedge clk);
    end
    if (smp_we == 2'b11) begin
      if (smp_addr != AW'(exp_idx) || smp_data != 8'd128) bad++;
      fills++;
    end
    check("R2 fill count", fills, 1 << AW);
    check("R2 fill order/value errors", bad, 0);
    @(negedge clk);
    check("R2 ready after fill", cs_ready, 1'b1);
    check("R10 idle rsp_valid", rsp_valid, 1'b0);

    crd(6'h00, d); check("R3 hw id", d, ID);
    crd(6'h12, d); check("R3 hw version", d, HV);
    crd(6'h13, d); check("R3 sw version", d, SV);
    crd(6'h05, d); check("R3 unassigned read", d, 8'h00);
    cwr(6'h00, 8'hFF); cwr(6'h13, 8'h00); cwr(6'h3E, 8'h11);
    crd(6'h00, d); check("R3 id after write", d, ID);
    crd(6'h13, d); check("R3 sw ver after write", d, SV);
    crd(6'h3E, d); check("R3 unassigned after write", d, 8'h00);

    set_ptr(32'h1234_5678);
    crd(6'h18, d); check("R4 ptr msb", d, 8'h12);
    crd(6'h19, d); check("R4 ptr byte2", d, 8'h34);
    crd(6'h1A, d); check("R4 ptr byte1", d, 8'h56);
    crd(6'h1B, d); check("R4 ptr lsb", d, 8'h78);

    pwr(32'h0000_8000, 8'd34); m[0] = 8'd34;
    check("R6 rc ch0 immediate", ch_rc, {m[1], m[0]});
    prd(32'h0000_8000, d); check("R6 rc ch0 readback", d, 8'd34);

    pwr(32'h8002, 8'h00); pwr(32'h8003, 8'h00); pwr(32'h8004, 8'h00); pwr(32'h8005, 8'd199);
    m[5] = 8'd199;
    pwr(32'h800A, 8'h00); pwr(32'h800B, 8'd31); m[11] = 8'd31;
    check("R8 divisor held before wrap", ch_div, 64'h0);
    check("R8 length held before wrap", ch_len, 32'h0);
    pulse_wrap(2'b10);
    check("R8 other channel wrap", ch_div[31:0], 32'h0);
    pulse_wrap(2'b01);
    check("R7 divisor ch0 big-endian", ch_div[31:0], 32'd199);
    check("R7 length ch0 big-endian", ch_len[15:0], 16'd31);
    pwr(32'h8006, 8'hA1); m[6] = 8'hA1;
    pwr(32'h8009, 8'h0F); m[9] = 8'h0F;
    pulse_wrap(2'b10);
    check("R7 divisor ch1 msb first", ch_div[63:32], 32'hA100_000F);

    pwr(32'h800E, 8'h55);
    check_exports("R9 undecoded write");
    prd(32'h800E, d); check("R9 undecoded read", d, 8'h00);
    prd(32'h0000_0005, d); check("R9 sample read", d, 8'h00);
    prd(32'hABCD_8000, d); check("R9 upper bits ignored", d, m[0]);

    pwr(32'h0000_4123, 8'h77);
    check("R5 ch1 strobe", smp_we, 2'b10);
    check("R5 ch1 index", smp_addr, 13'h0123);
    check("R5 ch1 data", smp_data, 8'h77);
    pwr(32'h0000_1FFF, 8'h3C);
    check("R5 ch0 top strobe", smp_we, 2'b01);
    check("R5 ch0 top index", smp_addr, 13'h1FFF);
    pwr(32'h0000_2000, 8'h99);
    check("R9 gap no strobe", smp_we, 2'b00);
    @(negedge clk);
    check("R5 strobe one cycle", smp_we, 2'b00);

    for (int it = 0; it < 300; it++) begin
      int kind, idx;
      logic [31:0] p;
      logic [7:0] v;
      kind = $urandom_range(0, 4);
      v = 8'($urandom());
      p = {16'($urandom()), 16'h0};
      case (kind)
        0: begin
          idx = $urandom_range(0, 13);
          pwr(p | (32'h8000 + 32'(idx)), v); m[idx] = v;
          check_exports("R6 R8 random reg write");
        end
        1: begin
          idx = $urandom_range(0, 13);
          prd(p | (32'h8000 + 32'(idx)), d);
          check("R7 random readback", d, m[idx]);
        end
        2: pulse_wrap(2'($urandom_range(1, 3)));
        3: begin
          idx = $urandom_range(0, (1 << AW) - 1);
          if ($urandom_range(0, 1) == 1) begin
            pwr(p | (32'h4000 + 32'(idx)), v);
            check("R5 random ch1 strobe", {smp_we, smp_addr, smp_data}, {2'b10, AW'(idx), v});
          end else begin
            pwr(p | 32'(idx), v);
            check("R5 random ch0 strobe", {smp_we, smp_addr, smp_data}, {2'b01, AW'(idx), v});
          end
        end
        default: begin
          idx = $urandom_range(16'h800E, 16'hFFFF);
          pwr(p | 32'(idx), v);
          check("R9 random undecoded no strobe", smp_we, 2'b00);
          check_exports("R9 random undecoded write");
        end
      endcase
    end
    pulse_wrap(2'b11);
    check_exports("R8 final wrap");

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule